// File: doc/BRIEF.md
# Per-Channel Receive Packet Builder

This block sits on one receive channel right after the decimating filter. It gathers the channel's complex samples into fixed-size packets of 126 samples and writes each packet into the write port of a packet FIFO. The header goes first, then the payload. Each sample becomes one 32-bit word, with I in the upper half and Q in the lower half.

The packet's timestamp is the master-clock tick count taken on the clock edge where the packet's first sample is accepted. Assembly time and drain time play no part in it. Two channels fed on the same sample strobes therefore produce packets with identical stamps. A stalled consumer cannot shift a stamp, because the stamp depends only on when the samples arrived.

Before a packet is started, the builder checks that the FIFO has room for the whole packet. If it does not, that packet's samples are consumed and discarded, and the next packet that is written reports the loss. The tick count comes either from an internal free-running counter or from a shared tick bus, chosen by a parameter. Within a packet, samples must arrive at least three cycles apart so that the two header words can be written in between.

Top module: `rx_packet_builder`

## Requirements
- R1: After reset no FIFO write occurs until a sample arrives, and the first packet starts on the first valid sample.
- R2: A packet is written as header word 0, then header word 1, then 126 sample words of value {I[15:0], Q[15:0]}, in arrival order.
- R3: Header word 0 holds the overrun flag in bit 31, the channel number (the CHAN_ID parameter) in bits 20:16, the payload length in bytes (504) in bits 15:0, and zero in bits 30:21.
- R4: Header word 1 equals the tick count on the clock edge that accepts the packet's first sample. The internal counter is zero during reset and rises by one on every clock after it.
- R5: Two packets in a row whose samples are spaced G cycles apart have stamps that differ by exactly 126*G.
- R6: Two builders fed the same sample strobes and the same tick values write packets with equal timestamps.
- R7: If the FIFO free space is below 128 words when a packet's first sample arrives, the whole packet (126 samples) is discarded and nothing is written for it.
- R8: The overrun flag is 1 in the first packet written after a discarded one, and 0 in the packets after that.
- R9: A drop of FIFO free space in the middle of a packet neither truncates nor delays that packet's words or its stamp.
- R10: With an external tick source, header word 1 is the tick input value at the first sample, and it wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe from the decimator |
| smp_i | input | 16 | In-phase sample |
| smp_q | input | 16 | Quadrature sample |
| tick_in | input | 32 | External tick count, used when USE_EXT_TICK=1 |
| fifo_space | input | 10 | Free words in the packet FIFO |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 32 | FIFO write word |

## Verification
The hardest state to reach is a discarded packet followed by a good one. The FIFO must report 127 free words exactly on the first sample of one packet and 128 free words on the next. Only then do the drop, the silent consumption of its 126 samples and the overrun report in the following header all occur in one run. The stimulus table sets free space per packet, at that boundary value, and marks one packet for a mid-packet stall.

A second builder is also driven, fed by an external tick bus. Its offset is shifted just before the last two packets, so their stamps straddle the 2^32 wrap.

// File: rtl/rxpb_pkg.sv
package rxpb_pkg;
   typedef enum logic [1:0] {
      W_HDR0 = 2'd0,
      W_HDR1 = 2'd1,
      W_SMP  = 2'd2
   } word_kind_t;

   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_HEAD0 = 3'd1,
      S_HEAD1 = 3'd2,
      S_FILL  = 3'd3,
      S_DROP  = 3'd4
   } seq_state_t;
endpackage

// File: rtl/rxpb_tick.sv
module rxpb_tick #(
   parameter int TS_W         = 32,
   parameter bit USE_EXT_TICK = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TS_W-1:0] tick_in,
   output logic [TS_W-1:0] tick_now
);
   generate
      if (USE_EXT_TICK) begin : g_ext
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign tick_now   = tick_in;
      end else begin : g_int
         logic [TS_W-1:0] cnt_q;
         logic            unused_tick;
         assign unused_tick = ^tick_in;
         always_ff @(posedge clk) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_q + TS_W'(1);
         end
         assign tick_now = cnt_q;
      end
   endgenerate
endmodule

// File: rtl/rxpb_sequencer.sv
module rxpb_sequencer
   import rxpb_pkg::*;
#(
   parameter int N_SMP   = 126,
   parameter int WORD_W  = 32,
   parameter int TS_W    = 32,
   parameter int SPACE_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               smp_valid,
   input  logic [WORD_W-1:0]  smp_word,
   input  logic [TS_W-1:0]    tick_now,
   input  logic [SPACE_W-1:0] fifo_space,
   output logic               req_valid,
   output word_kind_t         req_kind,
   output logic [WORD_W-1:0]  held_word,
   output logic [TS_W-1:0]    ts_q,
   output logic               ovr_flag,
   output logic               in_drop
);
   localparam int PKT_WORDS = N_SMP + 2;
   localparam int CNT_W     = $clog2(N_SMP + 1);

   seq_state_t        st;
   logic [CNT_W-1:0]  cnt;
   logic              pend;
   logic              ovr_pend;
   logic              room;

   assign room = (fifo_space >= SPACE_W'(PKT_WORDS));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         cnt       <= '0;
         pend      <= 1'b0;
         held_word <= '0;
         ts_q      <= '0;
         ovr_pend  <= 1'b0;
      end else begin
         unique case (st)
            S_IDLE: begin
               if (smp_valid) begin
                  cnt <= CNT_W'(1);
                  if (room) begin
                     st        <= S_HEAD0;
                     ts_q      <= tick_now;
                     held_word <= smp_word;
                     pend      <= 1'b1;
                  end else begin
                     st       <= S_DROP;
                     ovr_pend <= 1'b1;
                  end
               end
            end
            S_HEAD0: begin
               ovr_pend <= 1'b0;
               st       <= S_HEAD1;
            end
            S_HEAD1: st <= S_FILL;
            S_FILL: begin
               pend <= smp_valid;
               if (smp_valid) begin
                  held_word <= smp_word;
                  cnt       <= cnt + CNT_W'(1);
               end else if (cnt == CNT_W'(N_SMP)) begin
                  st  <= S_IDLE;
                  cnt <= '0;
               end
            end
            S_DROP: begin
               if (smp_valid) begin
                  if (cnt == CNT_W'(N_SMP - 1)) begin
                     st  <= S_IDLE;
                     cnt <= '0;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      req_valid = 1'b0;
      req_kind  = W_SMP;
      unique case (st)
         S_HEAD0: begin req_valid = 1'b1; req_kind = W_HDR0; end
         S_HEAD1: begin req_valid = 1'b1; req_kind = W_HDR1; end
         S_FILL:  begin req_valid = pend; req_kind = W_SMP;  end
         default: ;
      endcase
   end

   assign ovr_flag = ovr_pend;
   assign in_drop  = (st == S_DROP);

   // R8: the flag reported in a header is gone by the next header word
   a_r8_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_HEAD1) |-> !ovr_pend);

   // R7: sample count never runs past one packet
   a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt <= CNT_W'(N_SMP)));
endmodule

// File: rtl/rxpb_writer.sv
module rxpb_writer
   import rxpb_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int TS_W      = 32,
   parameter int CHAN_W    = 5,
   parameter int CHAN_ID   = 0,
   parameter int PAY_BYTES = 504
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  word_kind_t        req_kind,
   input  logic [WORD_W-1:0] held_word,
   input  logic [TS_W-1:0]   ts_q,
   input  logic              ovr_flag,
   output logic              fifo_wr,
   output logic [WORD_W-1:0] fifo_data,
   output word_kind_t        kind_q
);
   logic [WORD_W-1:0] hdr0_word;
   logic [WORD_W-1:0] ts_word;

   always_comb begin
      hdr0_word                 = '0;
      hdr0_word[WORD_W-1]       = ovr_flag;
      hdr0_word[16 +: CHAN_W]   = CHAN_W'(CHAN_ID);
      hdr0_word[15:0]           = 16'(PAY_BYTES);
   end

   generate
      if (TS_W == WORD_W) begin : g_ts_full
         assign ts_word = ts_q;
      end else begin : g_ts_pad
         assign ts_word = {{(WORD_W - TS_W){1'b0}}, ts_q};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fifo_wr   <= 1'b0;
         fifo_data <= '0;
         kind_q    <= W_HDR0;
      end else begin
         fifo_wr <= req_valid;
         if (req_valid) begin
            kind_q <= req_kind;
            unique case (req_kind)
               W_HDR0:  fifo_data <= hdr0_word;
               W_HDR1:  fifo_data <= ts_word;
               default: fifo_data <= held_word;
            endcase
         end
      end
   end

   // R2: header word 1 is always written on the cycle after header word 0
   a_r2_hdr_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr && kind_q == W_HDR0) |=> (fifo_wr && kind_q == W_HDR1));
endmodule

// File: rtl/rx_packet_builder.sv
module rx_packet_builder
   import rxpb_pkg::*;
#(
   parameter int N_SMP        = 126,
   parameter int IQ_W         = 16,
   parameter int TS_W         = 32,
   parameter int CHAN_W       = 5,
   parameter int CHAN_ID      = 0,
   parameter int SPACE_W      = 10,
   parameter bit USE_EXT_TICK = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_valid,
   input  logic [IQ_W-1:0]      smp_i,
   input  logic [IQ_W-1:0]      smp_q,
   input  logic [TS_W-1:0]      tick_in,
   input  logic [SPACE_W-1:0]   fifo_space,
   output logic                 fifo_wr,
   output logic [2*IQ_W-1:0]    fifo_data
);
   localparam int WORD_W    = 2 * IQ_W;
   localparam int PKT_WORDS = N_SMP + 2;
   localparam int PAY_BYTES = N_SMP * WORD_W / 8;

   initial begin
      assert (WORD_W == 32) else $error("sample word must be 32 bits");
      assert (N_SMP >= 2) else $error("packet needs at least two samples");
      assert (TS_W <= WORD_W) else $error("stamp wider than a word");
      assert (CHAN_W <= 15) else $error("channel field too wide");
      assert (CHAN_ID < (1 << CHAN_W)) else $error("channel id out of range");
      assert (PAY_BYTES < 65536) else $error("payload length overflows field");
      assert (PKT_WORDS < (1 << SPACE_W)) else $error("space port too narrow");
   end

   logic [TS_W-1:0]   tick_now;
   logic              req_valid;
   word_kind_t        req_kind;
   word_kind_t        kind_q;
   logic [WORD_W-1:0] held_word;
   logic [TS_W-1:0]   ts_q;
   logic              ovr_flag;
   logic              in_drop;

   rxpb_tick #(.TS_W(TS_W), .USE_EXT_TICK(USE_EXT_TICK)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .tick_now(tick_now)
   );

   rxpb_sequencer #(
      .N_SMP(N_SMP), .WORD_W(WORD_W), .TS_W(TS_W), .SPACE_W(SPACE_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
      .smp_word({smp_i, smp_q}), .tick_now(tick_now), .fifo_space(fifo_space),
      .req_valid(req_valid), .req_kind(req_kind), .held_word(held_word),
      .ts_q(ts_q), .ovr_flag(ovr_flag), .in_drop(in_drop)
   );

   rxpb_writer #(
      .WORD_W(WORD_W), .TS_W(TS_W), .CHAN_W(CHAN_W), .CHAN_ID(CHAN_ID),
      .PAY_BYTES(PAY_BYTES)
   ) u_wr (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .held_word(held_word), .ts_q(ts_q), .ovr_flag(ovr_flag),
      .fifo_wr(fifo_wr), .fifo_data(fifo_data), .kind_q(kind_q)
   );

   // R7: a discarded packet produces no FIFO traffic
   a_r7_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (in_drop && $past(in_drop)) |-> !fifo_wr);

   // R3: every first header word carries this channel's number
   a_r3_chan_field: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr && kind_q == W_HDR0) |-> (fifo_data[16 +: CHAN_W] == CHAN_W'(CHAN_ID)));
endmodule

// File: tb/test_rx_packet_builder.sv
module test_rx_packet_builder;
   localparam int CLK_PERIOD = 10;
   localparam int N          = 126;
   localparam int CHAN_A     = 3;
   localparam int CHAN_B     = 7;
   localparam int NVEC       = 5;
   // {gap[23:20], flags[19:16] = {2'b0, stall, roomy}, seed[15:0]}
   localparam logic [23:0] VEC [NVEC] = '{
      24'h31_1000, 24'h53_2000, 24'h40_3000, 24'h31_4000, 24'h61_5000 };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        smp_valid;
   logic [15:0] smp_i, smp_q;
   logic [9:0]  fifo_space;
   logic [31:0] tick_off;
   logic [31:0] cyc;
   logic [31:0] tick_b;
   logic        wr_a, wr_b;
   logic [31:0] data_a, data_b;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign tick_b = cyc + tick_off;

   always_ff @(posedge clk) begin
      if (!rst_n) cyc <= '0;
      else        cyc <= cyc + 32'd1;
   end

   rx_packet_builder #(.CHAN_ID(CHAN_A)) i_rx_packet_builder (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i),
      .smp_q(smp_q), .tick_in(tick_b), .fifo_space(fifo_space),
      .fifo_wr(wr_a), .fifo_data(data_a));

   rx_packet_builder #(.CHAN_ID(CHAN_B), .USE_EXT_TICK(1'b1)) i_rx_packet_builder_b (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i),
      .smp_q(smp_q), .tick_in(tick_b), .fifo_space(fifo_space),
      .fifo_wr(wr_b), .fifo_data(data_b));

   logic [31:0] cap_a [1024];
   logic [31:0] cap_b [1024];
   int n_a = 0;
   int n_b = 0;
   logic [31:0] rec_a [NVEC];
   logic [31:0] rec_b [NVEC];
   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always @(negedge clk) begin
      if (wr_a) begin if (n_a < 1024) cap_a[n_a] = data_a; n_a++; end
      if (wr_b) begin if (n_b < 1024) cap_b[n_b] = data_b; n_b++; end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic drive_pkt(input int e, input int gap, input bit roomy,
                            input bit stall, input logic [15:0] seed);
      for (int s = 0; s < N; s++) begin
         @(negedge clk);
         smp_valid = 1'b1;
         smp_i = seed + 16'(s);
         smp_q = ~(seed + 16'(s));
         if (s == 0) begin
            fifo_space = roomy ? 10'd128 : 10'd127;
            rec_a[e] = cyc;
            rec_b[e] = cyc + tick_off;
         end else if (stall && s >= 20 && s < 60) begin
            fifo_space = 10'd0;
         end else begin
            fifo_space = 10'd512;
         end
         @(negedge clk);
         smp_valid = 1'b0;
         repeat (gap - 2) @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int ptr;
      bit prev_drop;
      int bad_a, bad_b;
      logic [15:0] sd;
      rst_n = 1'b0; smp_valid = 1'b0; smp_i = '0; smp_q = '0;
      fifo_space = 10'd512; tick_off = '0;
      repeat (4) @(negedge clk);
      check(wr_a == 1'b0, "R1", "write during reset", 32'(wr_a), 32'd0);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      check(n_a == 0, "R1", "writes before first sample", 32'(n_a), 32'd0);

      for (int e = 0; e < NVEC; e++) begin
         if (e == 3) tick_off = 32'hFFFF_FFFF - cyc - 32'd5;
         drive_pkt(e, int'(VEC[e][23:20]), VEC[e][16], VEC[e][17], VEC[e][15:0]);
      end
      repeat (20) @(negedge clk);

      ptr = 0;
      prev_drop = 1'b0;
      for (int e = 0; e < NVEC; e++) begin
         if (!VEC[e][16]) begin
            prev_drop = 1'b1;
            continue;
         end
         check(cap_a[ptr] == {prev_drop, 10'd0, 5'(CHAN_A), 16'(4*N)}, "R3/R8",
               "header0 chan A", cap_a[ptr], {prev_drop, 10'd0, 5'(CHAN_A), 16'(4*N)});
         check(cap_b[ptr] == {prev_drop, 10'd0, 5'(CHAN_B), 16'(4*N)}, "R3/R8",
               "header0 chan B", cap_b[ptr], {prev_drop, 10'd0, 5'(CHAN_B), 16'(4*N)});
         check(cap_a[ptr+1] == rec_a[e], (e == 0) ? "R1/R4" : "R4",
               "stamp internal tick", cap_a[ptr+1], rec_a[e]);
         check(cap_b[ptr+1] == rec_b[e], "R10", "stamp external tick",
               cap_b[ptr+1], rec_b[e]);
         bad_a = 0; bad_b = 0;
         sd = VEC[e][15:0];
         for (int s = 0; s < N; s++) begin
            if (cap_a[ptr+2+s] != {sd + 16'(s), ~(sd + 16'(s))}) bad_a++;
            if (cap_b[ptr+2+s] != {sd + 16'(s), ~(sd + 16'(s))}) bad_b++;
         end
         check(bad_a == 0, VEC[e][17] ? "R9" : "R2", "payload words A", 32'(bad_a), 32'd0);
         check(bad_b == 0, "R2", "payload words B", 32'(bad_b), 32'd0);
         ptr += N + 2;
         prev_drop = 1'b0;
      end

      check(cap_a[N+3] - cap_a[1] == 32'(N*3), "R5", "stamp spacing",
            cap_a[N+3] - cap_a[1], 32'(N*3));
      check(cap_a[1] == cap_b[1], "R6", "equal stamps pkt0", cap_b[1], cap_a[1]);
      check(cap_a[N+3] == cap_b[N+3], "R6", "equal stamps pkt1", cap_b[N+3], cap_a[N+3]);
      check(cap_b[3*(N+2)+1] - cap_b[2*(N+2)+1] == 32'(N*3), "R10", "spacing across wrap",
            cap_b[3*(N+2)+1] - cap_b[2*(N+2)+1], 32'(N*3));
      check(cap_b[3*(N+2)+1] < cap_b[2*(N+2)+1], "R10", "stamp wrapped",
            cap_b[3*(N+2)+1], 32'd0);
      check(n_a == 4*(N+2), "R7", "word count A", 32'(n_a), 32'(4*(N+2)));
      check(n_b == 4*(N+2), "R7", "word count B", 32'(n_b), 32'(4*(N+2)));

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule